// File: doc/BRIEF.md
# Interrupt-Triggered Transfer Activation Controller

This controller sits between a set of peripheral interrupt sources and a data-transfer engine. Each source has a bit in a transfer-enable register. When a source raises its request while both that bit and the source's own interrupt enable are set, the controller claims the request. It reads the source's entry in a vector table to learn where the transfer descriptor lives, fetches the descriptor, and starts the engine with the descriptor and the source index. When the engine reports done, one descriptor bit picks the wrap-up. Either the source's request flag is cleared, or the source's transfer-enable bit is cleared and a one-cycle interrupt is sent to the CPU.

A read-skip option avoids memory traffic when one source fires repeatedly. The controller keeps the last fetched descriptor together with the index of its source. If the skip control bit is set and the same source activates again, both reads are skipped and the kept copy is reused. Writing the skip control bit to 0 discards the kept copy. The skip decision is taken at activation time, so a write made during a transfer only affects the next one.

Top module: `xfer_act_ctrl`

## Requirements
- R1: After reset, `xfer_en` and `skip_ctl` read 0 and `mem_req`, `eng_start`, `cpu_irq` and `src_clr` are all low.
- R2: A source is activated only when its `src_req`, `src_ie` and `xfer_en` bits are all 1. If any of the three is 0, no memory read and no engine start occur.
- R3: When several sources are eligible, the lowest index is served first. The others stay pending and are each served in ascending order once the earlier transfers finish.
- R4: A fetching activation of source i first reads address `VEC_BASE + 4*i`. It then reads the address given by the low `AW` bits of that word. It then pulses `eng_start` for one cycle, with `eng_src` = i and `eng_desc` = the second word read.
- R5: When `skip_ctl` is 1, the kept descriptor is valid and the activating source equals the source of the last fetch, no memory read is made. The engine receives the kept descriptor, even if memory has changed since.
- R6: Writing 0 to the skip control register (`reg_sel`=1, data bit 0) invalidates the kept descriptor. The next activation fetches, even if the bit is set back to 1 before that activation.
- R7: A write to the skip control bit while a transfer is in progress does not change that transfer. It governs the next activation.
- R8: Descriptor bit 0 = 0 selects flag-clear completion. In the cycle after `eng_done` is sampled, `src_clr` is one-hot on the active source, `cpu_irq` stays low and `xfer_en` is unchanged.
- R9: Descriptor bit 0 = 1 selects enable-clear completion. In the cycle after `eng_done` is sampled, `cpu_irq` pulses for exactly one cycle with `cpu_irq_src` = the source and `src_clr` = 0. Then that source's `xfer_en` bit reads 0, so its still-raised request is not served.
- R10: Between `eng_start` and the sampling of `eng_done`, the controller issues no memory read and no further `eng_start`, whatever requests are raised.
- R11: If a write to the transfer-enable register (`reg_sel`=0) lands in the same cycle as an enable-clear completion, the completing source's bit ends up 0. Every other bit takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: transfer-enable register, 1: skip control (bit 0) |
| reg_wdata | input | N_SRC | Register write data |
| xfer_en | output | N_SRC | Current transfer-enable register |
| skip_ctl | output | 1 | Current skip control bit |
| src_req | input | N_SRC | Source request flags |
| src_ie | input | N_SRC | Source interrupt enables |
| src_clr | output | N_SRC | One-cycle request-flag clear, one-hot |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| eng_start | output | 1 | One-cycle engine start |
| eng_src | output | IW | Source index of the running transfer |
| eng_desc | output | DW | Descriptor handed to the engine |
| eng_done | input | 1 | Engine completion pulse |
| cpu_irq | output | 1 | One-cycle CPU interrupt |
| cpu_irq_src | output | IW | Source index carried with `cpu_irq` |

## Verification
With a zero-latency memory, a fetching activation gives `eng_start` three cycles after the claiming edge: one for the vector read, one for the descriptor read and one to start. A skipping activation gives it one cycle after that edge. The bench does not rely on this latency. It polls at falling edges for `eng_start` and counts the reads between the previous completion and that start, which separates R4 from R5. The completion outputs fall in the single cycle after the edge that samples `eng_done`, and the bench samples them at the next falling edge. The register effects of R9 and R11 are read one falling edge later. Absence checks (R2, R10) watch every falling edge across a fixed window.

// File: rtl/xac_pkg.sv
package xac_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_VEC,
      ST_DSC,
      ST_START,
      ST_WAIT,
      ST_FIN
   } xac_state_t;
endpackage

// File: rtl/xac_prio.sv
module xac_prio #(
   parameter int N_SRC = 4,
   localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req,
   output logic [N_SRC-1:0] grant,
   output logic             any,
   output logic [IW-1:0]    idx
);
   logic [N_SRC-1:0] below;

   assign below[0] = 1'b0;
   for (genvar g = 1; g < N_SRC; g++) begin : g_below
      assign below[g] = below[g-1] | req[g-1];
   end
   assign grant = req & ~below;
   assign any   = |req;

   always_comb begin
      idx = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~req) == '0));
   p_grant_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (grant[idx] && ((req & ((N_SRC'(1) << idx) - N_SRC'(1))) == '0)));
endmodule

// File: rtl/xac_enreg.sv
module xac_enreg #(
   parameter int N_SRC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [N_SRC-1:0] wdata,
   input  logic [N_SRC-1:0] hw_clr,
   output logic [N_SRC-1:0] q
);
   for (genvar g = 0; g < N_SRC; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)         q[g] <= 1'b0;
         else if (hw_clr[g]) q[g] <= 1'b0;
         else if (we)        q[g] <= wdata[g];
      end

      p_hwclr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
         hw_clr[g] |=> !q[g]);
      p_write_takes_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (we && !hw_clr[g]) |=> (q[g] == $past(wdata[g])));
   end
endmodule

// File: rtl/xac_skipctl.sv
module xac_skipctl #(
   parameter int N_SRC = 4,
   localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_we,
   input  logic          ctl_wbit,
   input  logic          fetch_done,
   input  logic [IW-1:0] fetch_idx,
   output logic          ctl_q,
   output logic          vld_q,
   output logic [IW-1:0] last_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= 1'b0;
         vld_q  <= 1'b0;
         last_q <= '0;
      end else begin
         if (fetch_done) begin
            vld_q  <= 1'b1;
            last_q <= fetch_idx;
         end
         if (ctl_we) begin
            ctl_q <= ctl_wbit;
            if (!ctl_wbit) vld_q <= 1'b0;
         end
      end
   end

   p_wr0_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !ctl_wbit) |=> !vld_q);
   p_fetch_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_done && !(ctl_we && !ctl_wbit)) |=> (vld_q && last_q == $past(fetch_idx)));
endmodule

// File: rtl/xfer_act_ctrl.sv
module xfer_act_ctrl #(
   parameter int           N_SRC    = 4,
   parameter int           AW       = 16,
   parameter int           DW       = 32,
   parameter logic [AW-1:0] VEC_BASE = 16'h0100,
   localparam int          IW       = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic             reg_sel,
   input  logic [N_SRC-1:0] reg_wdata,
   output logic [N_SRC-1:0] xfer_en,
   output logic             skip_ctl,
   input  logic [N_SRC-1:0] src_req,
   input  logic [N_SRC-1:0] src_ie,
   output logic [N_SRC-1:0] src_clr,
   output logic             mem_req,
   output logic [AW-1:0]    mem_addr,
   input  logic             mem_rvalid,
   input  logic [DW-1:0]    mem_rdata,
   output logic             eng_start,
   output logic [IW-1:0]    eng_src,
   output logic [DW-1:0]    eng_desc,
   input  logic             eng_done,
   output logic             cpu_irq,
   output logic [IW-1:0]    cpu_irq_src
);
   import xac_pkg::*;

   if (N_SRC < 2) begin : g_bad_nsrc
      $error("xfer_act_ctrl: N_SRC must be at least 2");
   end
   if (DW < AW) begin : g_bad_dw
      $error("xfer_act_ctrl: DW must cover AW");
   end
   if (AW < IW + 2) begin : g_bad_aw
      $error("xfer_act_ctrl: AW too narrow for the vector table");
   end

   xac_state_t       state_q;
   logic [IW-1:0]    idx_q;
   logic [AW-1:0]    dptr_q;
   logic [DW-1:0]    desc_q;
   logic [N_SRC-1:0] eligible, grant, src_hot, hw_clr;
   logic             any_elig, skip_vld, skip_hit, fetch_done, fin_mode;
   logic [IW-1:0]    gidx, last_idx;

   assign eligible = src_req & src_ie & xfer_en;

   xac_prio #(.N_SRC(N_SRC)) u_prio (
      .clk(clk), .rst_n(rst_n), .req(eligible),
      .grant(grant), .any(any_elig), .idx(gidx)
   );

   xac_skipctl #(.N_SRC(N_SRC)) u_skip (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(reg_we && reg_sel), .ctl_wbit(reg_wdata[0]),
      .fetch_done(fetch_done), .fetch_idx(idx_q),
      .ctl_q(skip_ctl), .vld_q(skip_vld), .last_q(last_idx)
   );

   assign skip_hit   = skip_ctl && skip_vld && (gidx == last_idx);
   assign fetch_done = (state_q == ST_DSC) && mem_rvalid;
   assign fin_mode   = desc_q[0];
   assign src_hot    = N_SRC'(1) << idx_q;

   assign hw_clr  = ((state_q == ST_FIN) && fin_mode)  ? src_hot : '0;
   assign src_clr = ((state_q == ST_FIN) && !fin_mode) ? src_hot : '0;

   xac_enreg #(.N_SRC(N_SRC)) u_en (
      .clk(clk), .rst_n(rst_n),
      .we(reg_we && !reg_sel), .wdata(reg_wdata),
      .hw_clr(hw_clr), .q(xfer_en)
   );

   always_comb begin
      mem_req  = 1'b0;
      mem_addr = '0;
      if (state_q == ST_VEC) begin
         mem_req  = 1'b1;
         mem_addr = VEC_BASE + (AW'(idx_q) << 2);
      end else if (state_q == ST_DSC) begin
         mem_req  = 1'b1;
         mem_addr = dptr_q;
      end
   end

   assign eng_start   = (state_q == ST_START);
   assign eng_src     = idx_q;
   assign eng_desc    = desc_q;
   assign cpu_irq     = (state_q == ST_FIN) && fin_mode;
   assign cpu_irq_src = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         dptr_q  <= '0;
         desc_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (any_elig) begin
               idx_q   <= gidx;
               state_q <= skip_hit ? ST_START : ST_VEC;
            end
            ST_VEC: if (mem_rvalid) begin
               dptr_q  <= mem_rdata[AW-1:0];
               state_q <= ST_DSC;
            end
            ST_DSC: if (mem_rvalid) begin
               desc_q  <= mem_rdata;
               state_q <= ST_START;
            end
            ST_START: state_q <= ST_WAIT;
            ST_WAIT:  if (eng_done) state_q <= ST_FIN;
            ST_FIN:   state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   p_skip_noread_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && any_elig && skip_hit) |=> (!mem_req && eng_start));
   p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT) |-> (!mem_req && !eng_start));
   p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |=> !cpu_irq);
   p_fin_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_clr) && !(cpu_irq && (src_clr != '0)));
endmodule

// File: tb/tb_xfer_act_ctrl.sv
module tb_xfer_act_ctrl;
   localparam int          N        = 4;
   localparam int          AW       = 16;
   localparam int          DW       = 32;
   localparam int          IW       = 2;
   localparam logic [AW-1:0] VBASE  = 16'h0100;
   localparam logic [AW-1:0] DBASE  = 16'h0400;
   localparam time         CLK_PER  = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0, reg_sel = 1'b0;
   logic [N-1:0] reg_wdata = '0;
   logic [N-1:0] xfer_en, src_clr;
   logic [N-1:0] src_req = '0, src_ie = '1;
   logic skip_ctl, mem_req, mem_rvalid, eng_start, eng_done = 1'b0, cpu_irq;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata, eng_desc;
   logic [IW-1:0] eng_src, cpu_irq_src;

   logic [10:0]  gen = 11'd1;
   logic [N-1:0] dmode = '0;
   int total = 0, bad = 0, rd_cnt = 0, last_end = 0, cyc = 0;

   always #(CLK_PER/2) clk = ~clk;

   xfer_act_ctrl #(.N_SRC(N), .AW(AW), .DW(DW), .VEC_BASE(VBASE)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .xfer_en(xfer_en), .skip_ctl(skip_ctl),
      .src_req(src_req), .src_ie(src_ie), .src_clr(src_clr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .eng_start(eng_start), .eng_src(eng_src),
      .eng_desc(eng_desc), .eng_done(eng_done), .cpu_irq(cpu_irq),
      .cpu_irq_src(cpu_irq_src)
   );

   function automatic logic [DW-1:0] desc_of(int i, logic [10:0] g, logic m);
      return {16'hD500, 4'(i), g, m};
   endfunction

   assign mem_rvalid = mem_req;
   always_comb begin
      if (mem_addr >= VBASE && mem_addr < VBASE + AW'(4*N))
         mem_rdata = DW'(DBASE + ((mem_addr - VBASE) << 2));
      else
         mem_rdata = {16'hD500, 4'((mem_addr - DBASE) >> 4), gen,
                      dmode[IW'((mem_addr - DBASE) >> 4)]};
   end

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (mem_req) rd_cnt <= rd_cnt + 1;
      if (cyc > 100000) begin
         $display("FAIL watchdog act=%0d exp=<100000", cyc);
         bad = bad + 1;
         total = total + 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic sel, input logic [N-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   // Expect no memory read and no start over a window (R2 / R10 style).
   task automatic quiet(input int n, input string tag);
      bit seen = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (mem_req || eng_start) seen = 1;
      end
      chk(!seen, tag, 64'(seen), 64'd0);
   endtask

   // One transfer: wait for start, check it, hold, finish, check completion.
   task automatic run_one(input int src, input int reads, input logic [DW-1:0] exp_desc,
                          input int skipwr, input int enwr);
      bit got = 0, busy_bad = 0;
      logic [N-1:0] en_before, en_exp;
      for (int k = 0; k < 40 && !got; k++) begin
         @(negedge clk);
         if (eng_start) got = 1;
      end
      chk(got, "R4 start seen", 64'(got), 64'd1);
      chk(eng_src == IW'(src), "R3 source order", 64'(eng_src), 64'(src));
      chk(eng_desc == exp_desc, "R4/R5 descriptor", 64'(eng_desc), 64'(exp_desc));
      chk((rd_cnt - last_end) == reads, "R4/R5 read count", 64'(rd_cnt - last_end), 64'(reads));
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (mem_req || eng_start) busy_bad = 1;
         if (k == 0 && skipwr >= 0) begin
            reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = N'(skipwr);
         end else begin
            reg_we = 1'b0;
         end
      end
      chk(!busy_bad, "R10 quiet while busy", 64'(busy_bad), 64'd0);
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
      en_before = xfer_en;
      if (!exp_desc[0]) begin
         chk(src_clr == (N'(1) << src) && !cpu_irq, "R8 flag clear",
             64'({cpu_irq, src_clr}), 64'(N'(1) << src));
         src_req[src] = 1'b0;
      end else begin
         chk(cpu_irq && cpu_irq_src == IW'(src) && src_clr == '0, "R9 cpu irq",
             64'({cpu_irq, cpu_irq_src, src_clr}), 64'({1'b1, IW'(src), N'(0)}));
      end
      if (enwr >= 0) begin
         reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = N'(enwr);
      end
      last_end = rd_cnt;
      @(negedge clk);
      reg_we = 1'b0;
      chk(!cpu_irq && src_clr == '0, "R9 pulse width", 64'({cpu_irq, src_clr}), 64'd0);
      if (exp_desc[0]) begin
         en_exp = ((enwr >= 0) ? N'(enwr) : en_before) & ~(N'(1) << src);
         chk(xfer_en == en_exp, "R9/R11 enable after clear", 64'(xfer_en), 64'(en_exp));
      end else begin
         chk(xfer_en == en_before, "R8 enable kept", 64'(xfer_en), 64'(en_before));
      end
   endtask

   initial begin
      logic [DW-1:0] old_d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(xfer_en == '0 && !skip_ctl, "R1 reset regs", 64'({skip_ctl, xfer_en}), 64'd0);
      chk(!mem_req && !eng_start && !cpu_irq && src_clr == '0, "R1 reset outputs",
          64'({mem_req, eng_start, cpu_irq, src_clr}), 64'd0);

      // R2: each source, each missing qualifier
      for (int i = 0; i < N; i++) begin
         wr_reg(1'b0, ~(N'(1) << i));
         src_req[i] = 1'b1;
         quiet(6, "R2 enable bit off");
         wr_reg(1'b0, '1);
         src_ie[i] = 1'b0;
         quiet(6, "R2 source ie off");
         src_req[i] = 1'b0;
         src_ie[i] = 1'b1;
         quiet(2, "R2 request off");
         last_end = rd_cnt;
         src_req[i] = 1'b1;
         run_one(i, 2, desc_of(i, gen, 1'b0), -1, -1);
      end

      // R3: sweep every request pattern, served lowest first
      for (int p = 1; p < (1 << N); p++) begin
         last_end = rd_cnt;
         src_req = N'(p);
         for (int i = 0; i < N; i++) begin
            if (p[i]) run_one(i, 2, desc_of(i, gen, 1'b0), -1, -1);
         end
      end

      // R5: skip on repeat, stale copy reused
      wr_reg(1'b1, N'(1));
      last_end = rd_cnt;
      src_req[2] = 1'b1;
      run_one(2, 2, desc_of(2, gen, 1'b0), -1, -1);
      old_d = desc_of(2, gen, 1'b0);
      gen = gen + 11'd1;
      src_req[2] = 1'b1;
      run_one(2, 0, old_d, -1, -1);
      src_req[1] = 1'b1;
      run_one(1, 2, desc_of(1, gen, 1'b0), -1, -1);
      src_req[1] = 1'b1;
      run_one(1, 0, desc_of(1, gen, 1'b0), -1, -1);

      // R6: write 0 then 1 still forces a fetch
      wr_reg(1'b1, N'(0));
      wr_reg(1'b1, N'(1));
      last_end = rd_cnt;
      src_req[1] = 1'b1;
      run_one(1, 2, desc_of(1, gen, 1'b0), -1, -1);

      // R7: writes during a transfer govern the next one
      wr_reg(1'b1, N'(0));
      last_end = rd_cnt;
      src_req[0] = 1'b1;
      run_one(0, 2, desc_of(0, gen, 1'b0), 1, -1);
      chk(skip_ctl, "R7 control now set", 64'(skip_ctl), 64'd1);
      src_req[0] = 1'b1;
      run_one(0, 0, desc_of(0, gen, 1'b0), 0, -1);
      src_req[0] = 1'b1;
      run_one(0, 2, desc_of(0, gen, 1'b0), -1, -1);

      // R9: enable-clear completion, request stays unserved
      dmode[3] = 1'b1;
      src_req[3] = 1'b1;
      run_one(3, 2, desc_of(3, gen, 1'b1), -1, -1);
      quiet(6, "R9 cleared source ignored");
      src_req[3] = 1'b0;
      dmode[3] = 1'b0;
      wr_reg(1'b0, '1);

      // R11: software write collides with hardware clear
      dmode[2] = 1'b1;
      last_end = rd_cnt;
      src_req[2] = 1'b1;
      run_one(2, 2, desc_of(2, gen, 1'b1), -1, 4'b0101);
      src_req[2] = 1'b0;
      dmode[2] = 1'b0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule